// File: doc/BRIEF.md
# Deferred-Commit Store Buffer for a Write-Back Data Array

This block sits between the processor's load/store port and the data array of a write-back cache. A store is looked up and parked in one cycle: its tag result arrives on `tagHit` in the same cycle, and its address, data and byte enables are captured into a single holding entry. The data array is not written in that cycle. The held store is written into the array later, and only after its line is known to be resident. For a hit, that write happens in the first cycle in which the array is free. For a miss, the entry waits until the miss handler installs the line through the fill port, and is then written on top of the filled word.

Loads read the array and return their data one cycle later. When a load's address equals the held store's address, the bytes enabled in the entry replace the array bytes. This lets a load issued right after a store see the stored value. A store that arrives while the entry cannot drain in that cycle is refused with `stall`, and the processor must present it again. The tag array, the miss handler and the memory side are not part of this block. The word index is the low `IDX_W` bits of the word address, and each cache line is one word.

Top module: `wb_store_buffer`

## Requirements
- R1: While reset is asserted and after it is released, the holding entry is empty and every array word is zero. `loadValid` is 0 and `stall` is 0. A store held before reset is discarded.
- R2: A store presented while the entry is empty is accepted in that cycle, with `stall` at 0, whatever `tagHit` says.
- R3: A store captured with `tagHit` at 0 never changes the array until a fill for its address has arrived. A load of another address with the same index keeps returning the old word.
- R4: A store captured with `tagHit` at 1 is written into the array in the first following cycle in which there is no load and no fill. Load and fill cycles delay that write.
- R5: A load whose full address equals the held entry's address returns the array word with the entry's enabled bytes substituted. This holds whether the entry is confirmed or still waiting for its fill.
- R6: When the entry is written into the array, only the bytes whose `reqBe` bit was set at capture change. Bit b covers data bits 8b+7 down to 8b.
- R7: A missed entry stays held across fills to other addresses. A fill whose address equals the entry's address confirms the entry. The entry is then merged over the filled word in the next free array cycle.
- R8: A store that arrives while the entry is occupied and cannot be written in that cycle gets `stall` at 1 and is not captured. If the entry can be written in that same cycle, the new store is accepted without a stall.
- R9: `loadValid` is 1 exactly one cycle after a load request (`reqValid` 1, `reqWrite` 0), and `loadData` carries that load's result.
- R10: A fill writes `fillData` into the array word selected by the index of `fillAddr`. A fill takes precedence over writing the entry in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Processor request present |
| reqWrite | input | 1 | 1 for a store, 0 for a load |
| reqAddr | input | ADDR_W | Word address of the request |
| reqData | input | DATA_W | Store data |
| reqBe | input | DATA_W/8 | Store byte enables |
| tagHit | input | 1 | Tag lookup result for the store in this cycle |
| fillValid | input | 1 | Miss handler writes a line this cycle |
| fillAddr | input | ADDR_W | Word address of the installed line |
| fillData | input | DATA_W | Data of the installed line |
| stall | output | 1 | Store refused this cycle; present it again |
| loadValid | output | 1 | Load result valid (one cycle after the load) |
| loadData | output | DATA_W | Load result |

## Verification
The main stimulus is a sequence of stores, loads, fills and idle cycles. After each store, the array word is probed in two ways. An alias address with the same index and a different upper part reads the array directly. The store's own address reads the forwarded view. Comparing the two shows a deferred write apart from an early write, and shows a forwarded value apart from a committed one.

Full-word stores and stores with enables 0101 and 0011 show a correct byte merge apart from a whole-word overwrite. Loads placed directly behind a hit store show that the commit waits for an idle cycle. Missed stores are followed by a fill to a different address and then by a fill to the matching address, which shows whether the entry is confirmed by address or by any fill. A store issued while the entry is full is tried in two situations: once when the entry can drain in that cycle and once when it cannot, which separates a needed stall from a needless one.

// File: rtl/wbsb_pkg.sv
package wbsb_pkg;

  // Occupancy of the single holding entry
  typedef enum logic [1:0] {
    SB_EMPTY = 2'd0,   // nothing held
    SB_WAIT  = 2'd1,   // held, line not yet resident (tag miss)
    SB_READY = 2'd2    // held, line resident, waiting for a free array cycle
  } sb_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch request into the entry
    logic commit;   // write the merged entry into the array
    logic loadRd;   // read the array for a load
    logic fillWr;   // write fill data into the array
  } ctrl_stb_t;

endpackage

// File: rtl/wbsb_ctrl.sv
module wbsb_ctrl
  import wbsb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      tagHit,
  input  logic      fillValid,
  input  logic      fillMatch,
  output ctrl_stb_t stb,
  output logic      stall,
  output logic      entryValid,
  output logic      entryReady
);

  sb_state_e state, stateNxt;
  logic storeReq, loadReq, arrayBusy;

  always_comb begin
    storeReq   = reqValid & reqWrite;
    loadReq    = reqValid & ~reqWrite;
    // A store only touches the tag array; loads and fills occupy the data array
    arrayBusy  = loadReq | fillValid;

    stb.loadRd  = loadReq;
    stb.fillWr  = fillValid;
    stb.commit  = (state == SB_READY) & ~arrayBusy;
    stall       = storeReq & (state != SB_EMPTY) & ~stb.commit;
    stb.capture = storeReq & ~stall;

    stateNxt = state;
    if (stb.capture) begin
      stateNxt = tagHit ? SB_READY : SB_WAIT;
    end else if (stb.commit) begin
      stateNxt = SB_EMPTY;
    end else if ((state == SB_WAIT) && fillValid && fillMatch) begin
      stateNxt = SB_READY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SB_EMPTY;
    else        state <= stateNxt;
  end

  assign entryValid = (state != SB_EMPTY);
  assign entryReady = (state == SB_READY);

endmodule

// File: rtl/wbsb_dp.sv
module wbsb_dp
  import wbsb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrl_stb_t           stb,
  input  logic                entryValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  input  logic [DATA_W/8-1:0] reqBe,
  input  logic [ADDR_W-1:0]   fillAddr,
  input  logic [DATA_W-1:0]   fillData,
  output logic                fillMatch,
  output logic                loadValid,
  output logic [DATA_W-1:0]   loadData
);

  localparam int BE_W  = DATA_W / 8;
  localparam int DEPTH = 1 << IDX_W;

  logic [ADDR_W-1:0] bufAddr;
  logic [DATA_W-1:0] bufData;
  logic [BE_W-1:0]   bufBe;

  logic [DATA_W-1:0] mem [DEPTH];

  logic [IDX_W-1:0]  bufIdx, reqIdx, fillIdx;
  logic [DATA_W-1:0] memAtBuf, memAtReq;
  logic [DATA_W-1:0] commitWord, loadWord;
  logic              loadFwd;

  assign bufIdx   = bufAddr[IDX_W-1:0];
  assign reqIdx   = reqAddr[IDX_W-1:0];
  assign fillIdx  = fillAddr[IDX_W-1:0];
  assign memAtBuf = mem[bufIdx];
  assign memAtReq = mem[reqIdx];
  assign loadFwd  = entryValid && (bufAddr == reqAddr);
  assign fillMatch = (fillAddr == bufAddr);

  // Per-byte merge for both the commit write and the load forward path
  for (genvar b = 0; b < BE_W; b++) begin : g_byte
    assign commitWord[b*8 +: 8] = bufBe[b] ? bufData[b*8 +: 8] : memAtBuf[b*8 +: 8];
    assign loadWord[b*8 +: 8]   = (loadFwd && bufBe[b]) ? bufData[b*8 +: 8]
                                                        : memAtReq[b*8 +: 8];
  end

  // Holding entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bufAddr <= '0;
      bufData <= '0;
      bufBe   <= '0;
    end else if (stb.capture) begin
      bufAddr <= reqAddr;
      bufData <= reqData;
      bufBe   <= reqBe;
    end
  end

  // Data array: one write per cycle, fill first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (stb.fillWr) begin
      mem[fillIdx] <= fillData;
    end else if (stb.commit) begin
      mem[bufIdx] <= commitWord;
    end
  end

  // Registered load return
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loadValid <= 1'b0;
      loadData  <= '0;
    end else begin
      loadValid <= stb.loadRd;
      if (stb.loadRd) loadData <= loadWord;
    end
  end

endmodule

// File: rtl/wb_store_buffer.sv
module wb_store_buffer
  import wbsb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  input  logic [DATA_W/8-1:0] reqBe,
  input  logic                tagHit,
  input  logic                fillValid,
  input  logic [ADDR_W-1:0]   fillAddr,
  input  logic [DATA_W-1:0]   fillData,
  output logic                stall,
  output logic                loadValid,
  output logic [DATA_W-1:0]   loadData
);

  ctrl_stb_t stb;
  logic      entryValid;
  logic      entryReady;
  logic      fillMatch;

  wbsb_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .tagHit     (tagHit),
    .fillValid  (fillValid),
    .fillMatch  (fillMatch),
    .stb        (stb),
    .stall      (stall),
    .entryValid (entryValid),
    .entryReady (entryReady)
  );

  wbsb_dp #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .entryValid (entryValid),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .reqBe      (reqBe),
    .fillAddr   (fillAddr),
    .fillData   (fillData),
    .fillMatch  (fillMatch),
    .loadValid  (loadValid),
    .loadData   (loadData)
  );

endmodule

// File: rtl/wbsb_checker.sv
module wbsb_checker (
  input logic clk,
  input logic rst_n,
  input logic reqValid,
  input logic reqWrite,
  input logic tagHit,
  input logic fillValid,
  input logic fillMatch,
  input logic stall,
  input logic loadValid,
  input logic entryValid,
  input logic entryReady,
  input logic commit,
  input logic capture
);

  // R2: an accepted store occupies the entry next cycle
  p_accept_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqWrite && !stall) |=> entryValid);

  // R3: a store accepted on a miss is held unconfirmed
  p_miss_unconfirmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqWrite && !stall && !tagHit) |=> (entryValid && !entryReady));

  // R4: a store accepted on a hit is ready to write
  p_hit_confirmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqWrite && !stall && tagHit) |=> entryReady);

  // R4: a write without a new capture leaves the entry empty
  p_commit_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !capture) |=> !entryValid);

  // R7: a missed entry stays waiting until its own fill
  p_miss_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (entryValid && !entryReady && !(fillValid && fillMatch)) |=> (entryValid && !entryReady));

  // R8: a refused store leaves the entry in place
  p_stall_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> entryValid);

  // R9: load result one cycle after each load, never otherwise
  p_load_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqWrite) |=> loadValid);
  p_no_spurious_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reqValid && !reqWrite) |=> !loadValid);

endmodule

bind wb_store_buffer wbsb_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reqValid   (reqValid),
  .reqWrite   (reqWrite),
  .tagHit     (tagHit),
  .fillValid  (fillValid),
  .fillMatch  (fillMatch),
  .stall      (stall),
  .loadValid  (loadValid),
  .entryValid (entryValid),
  .entryReady (entryReady),
  .commit     (stb.commit),
  .capture    (stb.capture)
);

// File: tb/tb_wb_store_buffer.sv
module tb_wb_store_buffer;

  localparam int ADDR_W = 8;
  localparam int IDX_W  = 4;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  localparam logic [1:0] OP_IDLE  = 2'd0;
  localparam logic [1:0] OP_STORE = 2'd1;
  localparam logic [1:0] OP_LOAD  = 2'd2;
  localparam logic [1:0] OP_FILL  = 2'd3;

  typedef struct packed {
    logic [1:0]        op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [BE_W-1:0]   be;
    logic              hit;
    logic              expStall;
    logic [DATA_W-1:0] expLoad;
    logic [7:0]        req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{OP_LOAD,  8'h03, 32'h0,        4'h0, 1'b0, 1'b0, 32'h00000000, 8'd1},  // R1 array cleared
    '{OP_STORE, 8'h03, 32'h11223344, 4'hF, 1'b1, 1'b0, 32'h0,        8'd2},  // R2 accept on empty
    '{OP_LOAD,  8'h13, 32'h0,        4'h0, 1'b0, 1'b0, 32'h00000000, 8'd4},  // R4 not yet written
    '{OP_LOAD,  8'h03, 32'h0,        4'h0, 1'b0, 1'b0, 32'h11223344, 8'd5},  // R5 forwarded
    '{OP_IDLE,  8'h00, 32'h0,        4'h0, 1'b0, 1'b0, 32'h0,        8'd4},  // R4 idle slot
    '{OP_LOAD,  8'h13, 32'h0,        4'h0, 1'b0, 1'b0, 32'h11223344, 8'd4},  // R4 written
    '{OP_STORE, 8'h05, 32'hAABBCCDD, 4'h5, 1'b1, 1'b0, 32'h0,        8'd2},
    '{OP_IDLE,  8'h00, 32'h0,        4'h0, 1'b0, 1'b0, 32'h0,        8'd6},
    '{OP_LOAD,  8'h05, 32'h0,        4'h0, 1'b0, 1'b0, 32'h00BB00DD, 8'd6},  // R6 partial
    '{OP_STORE, 8'h07, 32'hDEADBEEF, 4'hF, 1'b0, 1'b0, 32'h0,        8'd2},  // miss accepted
    '{OP_IDLE,  8'h00, 32'h0,        4'h0, 1'b0, 1'b0, 32'h0,        8'd3},
    '{OP_LOAD,  8'h17, 32'h0,        4'h0, 1'b0, 1'b0, 32'h00000000, 8'd3},  // R3 untouched
    '{OP_STORE, 8'h09, 32'h00000001, 4'hF, 1'b1, 1'b1, 32'h0,        8'd8},  // R8 stall
    '{OP_LOAD,  8'h07, 32'h0,        4'h0, 1'b0, 1'b0, 32'hDEADBEEF, 8'd5},  // R5 pending miss
    '{OP_FILL,  8'h07, 32'h55555555, 4'h0, 1'b0, 1'b0, 32'h0,        8'd10},
    '{OP_LOAD,  8'h17, 32'h0,        4'h0, 1'b0, 1'b0, 32'h55555555, 8'd10}, // R10 fill word
    '{OP_STORE, 8'h09, 32'h01020304, 4'hF, 1'b1, 1'b0, 32'h0,        8'd8},  // R8 drain+accept
    '{OP_LOAD,  8'h17, 32'h0,        4'h0, 1'b0, 1'b0, 32'hDEADBEEF, 8'd7},  // R7 merged over fill
    '{OP_IDLE,  8'h00, 32'h0,        4'h0, 1'b0, 1'b0, 32'h0,        8'd4},
    '{OP_LOAD,  8'h09, 32'h0,        4'h0, 1'b0, 1'b0, 32'h01020304, 8'd4},
    '{OP_FILL,  8'h0A, 32'h12345678, 4'h0, 1'b0, 1'b0, 32'h0,        8'd10},
    '{OP_STORE, 8'h0A, 32'hAAAABBBB, 4'h3, 1'b1, 1'b0, 32'h0,        8'd2},
    '{OP_LOAD,  8'h0A, 32'h0,        4'h0, 1'b0, 1'b0, 32'h1234BBBB, 8'd5},  // R5 partial forward
    '{OP_IDLE,  8'h00, 32'h0,        4'h0, 1'b0, 1'b0, 32'h0,        8'd6},
    '{OP_LOAD,  8'h1A, 32'h0,        4'h0, 1'b0, 1'b0, 32'h1234BBBB, 8'd6}   // R6 partial commit
  };

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                reqValid = 1'b0;
  logic                reqWrite = 1'b0;
  logic [ADDR_W-1:0]   reqAddr = '0;
  logic [DATA_W-1:0]   reqData = '0;
  logic [BE_W-1:0]     reqBe = '0;
  logic                tagHit = 1'b0;
  logic                fillValid = 1'b0;
  logic [ADDR_W-1:0]   fillAddr = '0;
  logic [DATA_W-1:0]   fillData = '0;
  logic                stall;
  logic                loadValid;
  logic [DATA_W-1:0]   loadData;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  wb_store_buffer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .reqBe(reqBe), .tagHit(tagHit),
    .fillValid(fillValid), .fillAddr(fillAddr), .fillData(fillData),
    .stall(stall), .loadValid(loadValid), .loadData(loadData)
  );

  task automatic check(input bit ok, input int req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input logic [BE_W-1:0] be,
                       input logic hit);
    reqValid  = (op == OP_STORE) || (op == OP_LOAD);
    reqWrite  = (op == OP_STORE);
    reqAddr   = a;
    reqData   = d;
    reqBe     = be;
    tagHit    = hit;
    fillValid = (op == OP_FILL);
    fillAddr  = a;
    fillData  = d;
  endtask

  task automatic checkLoad(input logic [DATA_W-1:0] exp, input int req);
    check(loadValid === 1'b1, 9, {31'b0, loadValid}, 32'd1);  // R9 valid timing
    check(loadData === exp, req, loadData, exp);
  endtask

  // Watchdog
  initial begin
    #(20 * 100000);
    if (!finished) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    drive(OP_IDLE, '0, '0, '0, 1'b0);
    #5;
    check(stall === 1'b0, 1, {31'b0, stall}, 32'd0);
    check(loadValid === 1'b0, 1, {31'b0, loadValid}, 32'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0 && VECS[i-1].op == OP_LOAD) checkLoad(VECS[i-1].expLoad, int'(VECS[i-1].req));
      drive(VECS[i].op, VECS[i].addr, VECS[i].data, VECS[i].be, VECS[i].hit);
      #5;
      check(stall === VECS[i].expStall, (VECS[i].op == OP_STORE) ? int'(VECS[i].req) : 8,
            {31'b0, stall}, {31'b0, VECS[i].expStall});
    end
    @(negedge clk);
    checkLoad(VECS[NV-1].expLoad, int'(VECS[NV-1].req));

    // R7: fill to another address does not confirm the missed entry
    drive(OP_STORE, 8'h04, 32'hCAFEF00D, 4'hC, 1'b0);
    #5 check(stall === 1'b0, 2, {31'b0, stall}, 32'd0);
    @(negedge clk); drive(OP_FILL, 8'h14, 32'h00000077, '0, 1'b0);
    @(negedge clk); drive(OP_STORE, 8'h06, 32'h1, 4'hF, 1'b1);
    #5 check(stall === 1'b1, 7, {31'b0, stall}, 32'd1);
    @(negedge clk); drive(OP_FILL, 8'h04, 32'h00000088, '0, 1'b0);
    @(negedge clk); drive(OP_IDLE, '0, '0, '0, 1'b0);
    @(negedge clk); drive(OP_LOAD, 8'h14, '0, '0, 1'b0);
    @(negedge clk); drive(OP_IDLE, '0, '0, '0, 1'b0);
    checkLoad(32'hCAFE0088, 7);
    @(negedge clk);
    check(loadValid === 1'b0, 9, {31'b0, loadValid}, 32'd0);  // R9 no return after idle

    // R1: reset discards a held miss and clears the array
    drive(OP_STORE, 8'h02, 32'hFFFFFFFF, 4'hF, 1'b0);
    @(negedge clk); drive(OP_IDLE, '0, '0, '0, 1'b0);
    rst_n = 1'b0;
    #5;
    check(loadValid === 1'b0, 1, {31'b0, loadValid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    drive(OP_LOAD, 8'h02, '0, '0, 1'b0);
    @(negedge clk);
    checkLoad(32'h0, 1);
    drive(OP_STORE, 8'h0B, 32'h5, 4'hF, 1'b1);
    #5 check(stall === 1'b0, 1, {31'b0, stall}, 32'd0);
    @(negedge clk); drive(OP_LOAD, 8'h05, '0, '0, 1'b0);
    @(negedge clk); drive(OP_IDLE, '0, '0, '0, 1'b0);
    checkLoad(32'h0, 1);

    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule